// File: doc/BRIEF.md
# In-Band Loop Code Generator and Detector

This block sits on the serial bit stream of a T1 line and handles repeating in-band loop patterns. On the outgoing side it can replace the data with a pattern that repeats. The pattern is 1 to 8 bits long and is taken from the top bits of a programmable definition byte. When pattern sending is switched off, the outgoing data passes through unchanged. Each side has its own bit strobe, and the block acts only in the clock cycles where that strobe is high.

On the incoming side, two detectors watch the same received stream at the same time. One is set up with a loop-up pattern and the other with a loop-down pattern, and each has its own length. A detector declares a pattern present after a run of bit positions that agree with the repeating pattern, with a small number of disagreements allowed. It then holds a status flag until the pattern has been missing for a while. Each flag can drive a shared interrupt output through its own enable.

Top module: `loopcode_unit`

## Requirements
- R1: The length code `n` (0 to 7) selects a pattern of `n+1` bits. While sending is enabled, each transmit strobe sends the next pattern bit, starting with code bit 7 and going down to bit `7-n`, then starting again at bit 7.
- R2: While sending is disabled, each transmit strobe copies `tx_data_in` to `tx_data_out`.
- R3: The first strobe after sending is enabled sends the first pattern bit (code bit 7).
- R4: When the transmit length code differs from its value at the previous transmit strobe, that strobe sends the first pattern bit (code bit 7).
- R5: Each receive strobe shifts `rx_data_in` into an 8-bit history, which is zero after reset. A bit position matches when its last `n+1` history bits, oldest first, equal some rotation of the `n+1`-bit pattern.
- R6: Each receive strobe adds one position to a window count, and at most `MAX_ERR` non-matching positions may be counted in the window. A further non-matching position clears the count and the error tally. When the count reaches `WIN`, a detection occurs, and the count and the tally restart at zero.
- R7: On a detection, the detector's flag (`up_flag` for the loop-up pattern, `dn_flag` for the loop-down pattern) is high from the next cycle. The two detectors work independently and can both be set at once.
- R8: A set flag clears after `2*WIN` receive strobes pass with no new detection.
- R9: `irq` is high whenever a flag is set and that flag's enable (`up_irq_en`, `dn_irq_en`) is high.
- R10: After reset, `tx_data_out`, both flags and `irq` are low.
- R11: `tx_data_out` changes only after a transmit strobe, and the flags change only after a receive strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_bit_en | input | 1 | Transmit bit strobe |
| tx_data_in | input | 1 | Outgoing data before the pattern is inserted |
| tx_send_en | input | 1 | Replace outgoing data with the pattern |
| tx_code | input | 8 | Transmit pattern definition, MSB first |
| tx_len | input | 3 | Transmit length code (bits = code + 1) |
| tx_data_out | output | 1 | Outgoing bit, registered |
| rx_bit_en | input | 1 | Receive bit strobe |
| rx_data_in | input | 1 | Incoming data bit |
| up_code | input | 8 | Loop-up pattern definition |
| up_len | input | 3 | Loop-up length code |
| dn_code | input | 8 | Loop-down pattern definition |
| dn_len | input | 3 | Loop-down length code |
| up_irq_en | input | 1 | Interrupt enable for the loop-up flag |
| dn_irq_en | input | 1 | Interrupt enable for the loop-down flag |
| up_flag | output | 1 | Loop-up pattern present |
| dn_flag | output | 1 | Loop-down pattern present |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench builds the block with `WIN` set to 16 and `MAX_ERR` set to 1, instead of the default window of 48. This shortens both the detection window and the 32-position clearing interval, so a short run can set flags, refresh them, use up the error allowance and clear the flags again. Single-bit patterns, where one flipped bit gives exactly one non-matching position, are used to test the error allowance directly. An all-ones stream matches both the one-bit and the two-bit pattern at once, which tests the two detectors running together.

// File: rtl/loopcode_pkg.sv
// Shared widths, the per-pattern configuration type and the rotation
// match used by the loop code detectors.
// Assumes patterns are held MSB-first in a byte and are at most one byte long.
package loopcode_pkg;

    localparam int LC_CODE_W  = 8;
    localparam int LC_LEN_W   = $clog2(LC_CODE_W);
    localparam int LC_NUM_DET = 2;

    typedef struct packed {
        logic [LC_CODE_W-1:0] code;
        logic [LC_LEN_W-1:0]  len;
    } lc_cfg_t;

    // True when the newest len+1 history bits (oldest first) equal a rotation of the pattern.
    function automatic logic lc_window_match(input logic [LC_CODE_W-1:0] hist,
                                             input lc_cfg_t              cfg);
        int   span;
        int   idx;
        logic rot_ok;
        logic any_ok;
        span   = int'(cfg.len) + 1;
        any_ok = 1'b0;
        for (int r = 0; r < LC_CODE_W; r++) begin
            rot_ok = (r < span);
            for (int j = 0; j < LC_CODE_W; j++) begin
                if (j < span) begin
                    idx = (r + j) % span;
                    if (hist[LC_LEN_W'(span - 1 - j)] != cfg.code[LC_LEN_W'(LC_CODE_W - 1 - idx)])
                        rot_ok = 1'b0;
                end
            end
            any_ok = any_ok | rot_ok;
        end
        return any_ok;
    endfunction

endpackage

// File: rtl/lc_generator.sv
// Transmit pattern inserter. On each strobe, either forwards the incoming
// bit or sends the next bit of the repeating pattern, MSB first.
// Assumes: the length code is sampled on strobes only; if it differs from
// the value seen at the previous strobe, the pattern starts again at bit 0.
module lc_generator
    import loopcode_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    bit_en,
    input  logic    bit_in,
    input  logic    send_en,
    input  lc_cfg_t cfg,
    output logic    bit_out
);

    logic [LC_LEN_W-1:0] ph;
    logic [LC_LEN_W-1:0] ph_eff;
    logic [LC_LEN_W-1:0] ph_nx;
    logic [LC_LEN_W-1:0] len_q;
    logic                pick;

    // Pick the phase for this strobe, the bit to send and the phase after it.
    always_comb begin
        ph_eff = (cfg.len != len_q) ? '0 : ph;
        if (!send_en) begin
            ph_nx = '0;
        end else if (ph_eff == cfg.len) begin
            ph_nx = '0;
        end else begin
            ph_nx = ph_eff + 1'b1;
        end
        pick = send_en ? cfg.code[LC_LEN_W'(LC_CODE_W - 1) - ph_eff] : bit_in;
    end

    // Register the phase, the length seen and the outgoing bit on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= '0;
            len_q   <= '0;
            bit_out <= 1'b0;
        end else if (bit_en) begin
            ph      <= ph_nx;
            len_q   <= cfg.len;
            bit_out <= pick;
        end
    end

endmodule

// File: rtl/lc_detector.sv
// One receive pattern detector. Keeps a byte of bit history, counts a window of
// positions with a limited number of misses, and holds a presence flag
// until 2*WIN strobes pass without a new detection.
// Assumes one strobe per received bit; the configuration may change at any time.
module lc_detector
    import loopcode_pkg::*;
#(
    parameter int WIN     = 48,
    parameter int MAX_ERR = 1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    bit_en,
    input  logic    bit_in,
    input  lc_cfg_t cfg,
    output logic    found
);

    localparam int HOLD = 2 * WIN;
    localparam int CW   = $clog2(WIN + 1);
    localparam int EW   = $clog2(MAX_ERR + 2);
    localparam int QW   = $clog2(HOLD + 1);

    logic [LC_CODE_W-1:0] hist;
    logic [LC_CODE_W-1:0] hist_nx;
    logic [CW-1:0]        cnt;
    logic [CW-1:0]        cnt_nx;
    logic [EW-1:0]        err;
    logic [EW-1:0]        err_nx;
    logic [QW-1:0]        quiet;
    logic [QW-1:0]        quiet_nx;
    logic                 found_nx;
    logic                 pos_ok;
    logic                 hit;

    assign hist_nx = {hist[LC_CODE_W-2:0], bit_in};
    assign pos_ok  = lc_window_match(hist_nx, cfg);

    // Advance the window count and the miss tally, and detect a full window.
    always_comb begin
        cnt_nx = cnt;
        err_nx = err;
        if (pos_ok) begin
            cnt_nx = cnt + 1'b1;
        end else if (err < EW'(MAX_ERR)) begin
            cnt_nx = cnt + 1'b1;
            err_nx = err + 1'b1;
        end else begin
            cnt_nx = '0;
            err_nx = '0;
        end
        hit = (cnt_nx == CW'(WIN));
        if (hit) begin
            cnt_nx = '0;
            err_nx = '0;
        end
    end

    // Set the flag on a detection, or clear it after a long quiet stretch.
    always_comb begin
        found_nx = found;
        quiet_nx = quiet;
        if (hit) begin
            found_nx = 1'b1;
            quiet_nx = '0;
        end else if (found) begin
            if (quiet == QW'(HOLD - 1)) begin
                found_nx = 1'b0;
                quiet_nx = '0;
            end else begin
                quiet_nx = quiet + 1'b1;
            end
        end
    end

    // Register the detector state on each receive strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist  <= '0;
            cnt   <= '0;
            err   <= '0;
            quiet <= '0;
            found <= 1'b0;
        end else if (bit_en) begin
            hist  <= hist_nx;
            cnt   <= cnt_nx;
            err   <= err_nx;
            quiet <= quiet_nx;
            found <= found_nx;
        end
    end

endmodule

// File: rtl/loopcode_unit.sv
// In-band loop code unit: one transmit pattern generator and two receive
// detectors (loop-up, loop-down) with a masked, combined interrupt.
// Assumes separate transmit and receive bit strobes in one clock domain.
module loopcode_unit
    import loopcode_pkg::*;
#(
    parameter int WIN     = 48,
    parameter int MAX_ERR = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_bit_en,
    input  logic       tx_data_in,
    input  logic       tx_send_en,
    input  logic [7:0] tx_code,
    input  logic [2:0] tx_len,
    output logic       tx_data_out,
    input  logic       rx_bit_en,
    input  logic       rx_data_in,
    input  logic [7:0] up_code,
    input  logic [2:0] up_len,
    input  logic [7:0] dn_code,
    input  logic [2:0] dn_len,
    input  logic       up_irq_en,
    input  logic       dn_irq_en,
    output logic       up_flag,
    output logic       dn_flag,
    output logic       irq
);

    lc_cfg_t                tx_cfg;
    lc_cfg_t                det_cfg [LC_NUM_DET];
    logic [LC_NUM_DET-1:0]  det_found;
    logic [LC_NUM_DET-1:0]  det_ie;

    assign tx_cfg     = {tx_code, tx_len};
    assign det_cfg[0] = {up_code, up_len};
    assign det_cfg[1] = {dn_code, dn_len};
    assign det_ie     = {dn_irq_en, up_irq_en};

    lc_generator u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (tx_bit_en),
        .bit_in  (tx_data_in),
        .send_en (tx_send_en),
        .cfg     (tx_cfg),
        .bit_out (tx_data_out)
    );

    for (genvar g = 0; g < LC_NUM_DET; g++) begin : g_det
        lc_detector #(
            .WIN     (WIN),
            .MAX_ERR (MAX_ERR)
        ) u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .bit_en (rx_bit_en),
            .bit_in (rx_data_in),
            .cfg    (det_cfg[g]),
            .found  (det_found[g])
        );
    end

    assign up_flag = det_found[0];
    assign dn_flag = det_found[1];
    assign irq     = |(det_found & det_ie);

endmodule

// File: rtl/loopcode_unit_chk.sv
// Checker bound to loopcode_unit. It watches only the ports of the unit.
// Assumes the reset is synchronous and active-low.
module loopcode_unit_chk #(
    parameter int WIN     = 48,
    parameter int MAX_ERR = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_bit_en,
    input logic       tx_data_in,
    input logic       tx_send_en,
    input logic [7:0] tx_code,
    input logic [2:0] tx_len,
    input logic       tx_data_out,
    input logic       rx_bit_en,
    input logic       rx_data_in,
    input logic [7:0] up_code,
    input logic [2:0] up_len,
    input logic [7:0] dn_code,
    input logic [2:0] dn_len,
    input logic       up_irq_en,
    input logic       dn_irq_en,
    input logic       up_flag,
    input logic       dn_flag,
    input logic       irq
);

    logic [31:0] seen;

    // Count receive strobes since reset, saturating at the window size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= '0;
        end else if (rx_bit_en && seen < 32'(WIN)) begin
            seen <= seen + 1'b1;
        end
    end

    // R2: with sending off, the strobed input bit appears at the output.
    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        tx_bit_en && !tx_send_en |=> tx_data_out == $past(tx_data_in));

    // R1: a one-bit pattern always sends code bit 7.
    a_r1_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        tx_bit_en && tx_send_en && tx_len == 3'd0 |=> tx_data_out == $past(tx_code[7]));

    // R11: the output holds between transmit strobes.
    a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_bit_en |=> $stable(tx_data_out));

    // R11: the flags hold between receive strobes.
    a_r11_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_bit_en |=> $stable(up_flag) && $stable(dn_flag));

    // R6: no flag can rise before a full window of strobes has been seen.
    a_r6_min_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_flag) || $rose(dn_flag) |-> seen >= 32'(WIN));

    // R9: a rising interrupt always has a set flag behind it.
    a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> up_flag || dn_flag);

endmodule

bind loopcode_unit loopcode_unit_chk #(.WIN(WIN), .MAX_ERR(MAX_ERR)) u_chk (.*);

// File: tb/loopcode_unit_test.sv
module loopcode_unit_test;

    localparam int TB_WIN = 16;
    localparam int TB_ERR = 1;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tx_bit_en, tx_data_in, tx_send_en;
    logic [7:0] tx_code;
    logic [2:0] tx_len;
    logic       tx_data_out;
    logic       rx_bit_en, rx_data_in;
    logic [7:0] up_code, dn_code;
    logic [2:0] up_len, dn_len;
    logic       up_irq_en, dn_irq_en;
    logic       up_flag, dn_flag, irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    string ttag = "R10";
    string rtag = "R10";

    // bench model state
    logic       m_out;
    int         m_k;
    logic [2:0] m_len_last;
    logic [7:0] m_hist;
    int         m_cnt [2];
    int         m_err [2];
    int         m_quiet [2];
    logic       m_flag [2];

    // receive source pattern
    logic [7:0] src_code;
    logic [2:0] src_len;
    int         src_k;

    always #2 clk = ~clk;

    loopcode_unit #(.WIN(TB_WIN), .MAX_ERR(TB_ERR)) uut (
        .clk(clk), .rst_n(rst_n),
        .tx_bit_en(tx_bit_en), .tx_data_in(tx_data_in), .tx_send_en(tx_send_en),
        .tx_code(tx_code), .tx_len(tx_len), .tx_data_out(tx_data_out),
        .rx_bit_en(rx_bit_en), .rx_data_in(rx_data_in),
        .up_code(up_code), .up_len(up_len), .dn_code(dn_code), .dn_len(dn_len),
        .up_irq_en(up_irq_en), .dn_irq_en(dn_irq_en),
        .up_flag(up_flag), .dn_flag(dn_flag), .irq(irq)
    );

    function automatic logic win_match(logic [7:0] h, logic [7:0] c, logic [2:0] lc);
        int   L;
        logic e [16];
        L = int'(lc) + 1;
        for (int i = 0; i < 16; i++) e[i] = c[7 - (i % L)];
        for (int r = 0; r < L; r++) begin
            logic same;
            same = 1'b1;
            for (int j = 0; j < L; j++) if (h[L - 1 - j] != e[r + j]) same = 1'b0;
            if (same) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic model_update();
        if (tx_bit_en) begin
            if (tx_len != m_len_last) m_k = 0;
            if (tx_send_en) begin
                m_out = tx_code[7 - (m_k % (int'(tx_len) + 1))];
                m_k++;
            end else begin
                m_out = tx_data_in;
                m_k   = 0;
            end
            m_len_last = tx_len;
        end
        if (rx_bit_en) begin
            m_hist = {m_hist[6:0], rx_data_in};
            for (int d = 0; d < 2; d++) begin
                logic ok;
                ok = (d == 0) ? win_match(m_hist, up_code, up_len)
                              : win_match(m_hist, dn_code, dn_len);
                if (ok) m_cnt[d]++;
                else if (m_err[d] < TB_ERR) begin m_cnt[d]++; m_err[d]++; end
                else begin m_cnt[d] = 0; m_err[d] = 0; end
                if (m_cnt[d] == TB_WIN) begin
                    m_cnt[d] = 0; m_err[d] = 0; m_flag[d] = 1'b1; m_quiet[d] = 0;
                end else if (m_flag[d]) begin
                    m_quiet[d]++;
                    if (m_quiet[d] == 2 * TB_WIN) begin m_flag[d] = 1'b0; m_quiet[d] = 0; end
                end
            end
        end
    endtask

    // One clock: inputs already driven at the falling edge; update the model, compare at the next falling edge.
    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        check(ttag, "tx_data_out", tx_data_out, m_out);
        check(rtag, "up_flag", up_flag, m_flag[0]);
        check(rtag, "dn_flag", dn_flag, m_flag[1]);
        check("R9", "irq", irq, (m_flag[0] & up_irq_en) | (m_flag[1] & dn_irq_en));
    endtask

    task automatic run(input int n, input int tx_pct, input int rx_pct, input int noise, input int flip_every);
        for (int i = 0; i < n; i++) begin
            logic rb;
            rb         = src_code[7 - (src_k % (int'(src_len) + 1))];
            tx_bit_en  = ($urandom % 100) < tx_pct;
            tx_data_in = $urandom % 2;
            rx_bit_en  = ($urandom % 100) < rx_pct;
            if (rx_bit_en) begin
                if (noise > 0 && ($urandom % 100) < noise) rb = ~rb;
                if (flip_every > 0 && (src_k % flip_every) == flip_every - 1) rb = ~rb;
                src_k++;
            end
            rx_data_in = rb;
            step();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7919));
        rst_n = 1'b0;
        tx_bit_en = 0; tx_data_in = 0; tx_send_en = 0; tx_code = 0; tx_len = 0;
        rx_bit_en = 0; rx_data_in = 0; up_code = 8'hB0; up_len = 3'd3;
        dn_code = 8'h40; dn_len = 3'd1; up_irq_en = 1; dn_irq_en = 1;
        m_out = 0; m_k = 0; m_len_last = 0; m_hist = 0;
        for (int d = 0; d < 2; d++) begin m_cnt[d] = 0; m_err[d] = 0; m_quiet[d] = 0; m_flag[d] = 0; end
        src_code = 8'h00; src_len = 3'd0; src_k = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check("R10", "tx_data_out", tx_data_out, 1'b0);
        check("R10", "up_flag", up_flag, 1'b0);
        check("R10", "dn_flag", dn_flag, 1'b0);
        check("R10", "irq", irq, 1'b0);
        rst_n = 1'b1;

        // R1 with R5: every length, random pattern, random strobe gaps, random receive data
        ttag = "R1"; rtag = "R5"; tx_send_en = 1;
        for (int len = 0; len < 8; len++) begin
            tx_code  = 8'($urandom);
            tx_len   = 3'(len);
            src_code = 8'($urandom);
            src_len  = 3'($urandom % 8);
            run(4 * (len + 1) + 6, 75, 70, 40, 0);
        end

        // R2: pass-through
        ttag = "R2"; tx_send_en = 0;
        run(30, 70, 50, 50, 0);
        // R3: re-enable restarts at code bit 7
        ttag = "R3"; tx_send_en = 1; tx_code = 8'h6D; tx_len = 3'd4;
        run(20, 80, 50, 50, 0);
        // R4: length change in mid pattern
        ttag = "R4"; tx_len = 3'd6;
        run(5, 100, 50, 50, 0);
        tx_len = 3'd2;
        run(12, 100, 50, 50, 0);
        tx_len = 3'd7;
        run(3, 60, 50, 50, 0);
        ttag = "R1";

        // R7: clean loop-up pattern sets up_flag only
        rtag = "R7"; up_code = 8'hB0; up_len = 3'd3; dn_code = 8'h40; dn_len = 3'd1;
        src_code = 8'hB0; src_len = 3'd3; src_k = 1;
        run(60, 50, 100, 0, 0);
        check("R7", "up_flag after clean pattern", up_flag, 1'b1);
        check("R7", "dn_flag stays clear", dn_flag, 1'b0);

        // R8: all zeros match neither pattern; flag clears
        rtag = "R8"; src_code = 8'h00; src_len = 3'd0;
        run(3 * TB_WIN, 50, 100, 0, 0);
        check("R8", "up_flag cleared", up_flag, 1'b0);

        // R7: all ones matches both detectors at once
        rtag = "R7"; up_code = 8'h80; up_len = 3'd0; dn_code = 8'hC0; dn_len = 3'd1;
        src_code = 8'hFF; src_len = 3'd0;
        run(60, 50, 100, 0, 0);
        check("R7", "up_flag concurrent", up_flag, 1'b1);
        check("R7", "dn_flag concurrent", dn_flag, 1'b1);

        // R9: interrupt enables
        up_irq_en = 0; dn_irq_en = 0; run(3, 50, 100, 0, 0);
        check("R9", "irq masked", irq, 1'b0);
        up_irq_en = 1; run(3, 50, 100, 0, 0);
        up_irq_en = 0; dn_irq_en = 1; run(3, 50, 100, 0, 0);
        up_irq_en = 1;

        // R6: misses too close together stop detection
        rtag = "R6";
        run(5 * TB_WIN, 50, 100, 0, 7);
        check("R6", "up_flag after dense misses", up_flag, 1'b0);
        check("R6", "dn_flag after dense misses", dn_flag, 1'b0);
        // R6: sparse misses are tolerated
        run(4 * TB_WIN, 50, 100, 0, 12);
        run(4 * TB_WIN, 50, 90, 0, 20);

        // R11 and R5: long random run with changing configuration
        ttag = "R11"; rtag = "R5";
        for (int blk = 0; blk < 20; blk++) begin
            tx_code    = 8'($urandom);
            tx_len     = 3'($urandom % 8);
            tx_send_en = ($urandom % 4) != 0;
            up_code    = 8'($urandom);
            up_len     = 3'($urandom % 4);
            dn_code    = 8'($urandom);
            dn_len     = 3'($urandom % 4);
            up_irq_en  = $urandom % 2;
            dn_irq_en  = $urandom % 2;
            src_code   = ($urandom % 2) ? up_code : dn_code;
            src_len    = (src_code == up_code) ? up_len : dn_len;
            run(150, 60, 60, $urandom % 6, 0);
        end

        finish_run();
    end

endmodule